// File: doc/BRIEF.md
# Transactional Region Nesting Controller

This block keeps the transactional-memory bookkeeping for a single logical processor. The front end hands it decoded region-begin and region-end events, suspend/resume events for read tracking, and asynchronous abort requests. From these the block keeps a nesting depth, an active condition, a suspended-tracking flag and the fallback program counter captured at the outermost begin. When the last open region closes, it asks the memory side to commit atomically and holds that request until a pass/fail answer arrives.

Illegal uses are reported as faults that change no state. A feature-disabled begin or end, or an end carrying a lock prefix, raises an undefined-opcode fault. An end outside any region raises a general-protection fault with error code zero. Every abort cause shares one path. That path clears the nesting state, pulses the register-restore and memory-discard strobes for one cycle, reports a cause code and presents the redirect target.

The controller is built around four named states. IDLE means no region is open. RUN means at least one region is open. COMMIT means a commit request is outstanding. ABORT is the single cycle in which the abort strobes are presented. The transitions are:
- IDLE→RUN on an accepted begin.
- RUN→COMMIT on the end that drops the depth to zero.
- COMMIT→IDLE on a passing response.
- RUN/COMMIT→ABORT on an external abort, a failing response, a nesting overflow or an end while suspended.
- ABORT→IDLE unconditionally.

Top module: `txn_nest_ctrl`

## Requirements
- R1: After reset, the block is inactive with depth 0. No fault, commit request, abort strobe or stall is asserted, and the status output is 0.
- R2: An end is recognised only when end_opc equals 24'h0F01D5 (first byte in bits 23:16) and other_pfx is low. Any other end_v input is ignored and has no effect on outputs or state.
- R3: A begin or end with feat_en low, or a recognised end with lock_pfx high, raises fault_ud for one cycle, starting the cycle after the event. Depth and activity are left unchanged.
- R4: A recognised, permitted end while inactive raises fault_gp (error code zero) for one cycle, starting the cycle after the event. State is left unchanged.
- R5: An accepted begin makes the block active and increments depth. begin_fb is captured only when the depth goes from 0 to 1.
- R6: A permitted end while active and not suspended decrements depth. Only when depth reaches 0 is commit_req raised. It stays high until commit_rsp_v. While commit_req or the abort strobes are high, stall_o is high and begin, end and suspend events are ignored.
- R7: A passing response (commit_rsp_ok=1) makes the block inactive with no abort. A failing response enters abort with status bit 1 set.
- R8: Abort asserts restore_o, discard_o and redirect_v for exactly one cycle, together with the cause in status_o. Depth, activity and suspension are cleared.
- R9: When mode64 is high, redirect_pc is the full captured fallback. Otherwise its upper 32 bits are zero and its lower 32 bits are those of the fallback.
- R10: While active, susp_set sets and susp_clr clears the suspension flag. An end while suspended enters abort with status bit 3 set, without a commit request.
- R11: A begin while depth equals MAX_DEPTH enters abort with status bit 2 set. Depth never exceeds MAX_DEPTH.
- R12: ext_abort while active, including while a commit is pending, enters abort with status bit 0. It overrides any same-cycle begin, end or response. While inactive, ext_abort is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| feat_en | input | 1 | Transactional-memory feature enabled |
| mode64 | input | 1 | 64-bit processor mode |
| lock_pfx | input | 1 | Lock prefix present on the end instruction |
| other_pfx | input | 1 | Any other prefix present on the end instruction |
| begin_v | input | 1 | Decoded region-begin event |
| begin_fb | input | 64 | Fallback address carried by the begin |
| end_v | input | 1 | Candidate region-end event |
| end_opc | input | 24 | Opcode bytes of the candidate end |
| susp_set | input | 1 | Suspend read tracking |
| susp_clr | input | 1 | Resume read tracking |
| ext_abort | input | 1 | Asynchronous abort request |
| commit_rsp_v | input | 1 | Commit response valid |
| commit_rsp_ok | input | 1 | Commit response pass (1) / fail (0) |
| stall_o | output | 1 | Region events not accepted this cycle |
| commit_req | output | 1 | Atomic commit request |
| fault_ud | output | 1 | Undefined-opcode fault pulse |
| fault_gp | output | 1 | General-protection fault pulse, error code 0 |
| restore_o | output | 1 | Register-restore strobe |
| discard_o | output | 1 | Memory-discard strobe |
| status_o | output | 4 | Abort cause: bit0 external, bit1 commit fail, bit2 overflow, bit3 suspended end |
| redirect_v | output | 1 | Redirect target valid |
| redirect_pc | output | 64 | Redirect program counter |
| active_o | output | 1 | Inside a transactional region |
| depth_o | output | $clog2(MAX_DEPTH+1) | Current nesting depth |

## Verification
The assertions assume that begin_v and end_v never arrive together. They also assume that a commit response appears only while commit_req is high, and that the upstream decoder holds a stalled event rather than dropping it. The stimulus drives at most one region event per cycle. It issues commit responses only in cycles where the reference model expects a pending request. Events driven during a stall are included deliberately and are expected to have no effect on outputs or state.

// File: rtl/txn_pkg.sv
package txn_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_RUN,
        ST_COMMIT,
        ST_ABORT
    } txn_state_e;

    localparam int CAUSE_W        = 4;
    localparam int CAUSE_EXT      = 0;
    localparam int CAUSE_CONFLICT = 1;
    localparam int CAUSE_OVF      = 2;
    localparam int CAUSE_SUSP     = 3;

    localparam int          OPC_W      = 24;
    localparam logic [23:0] END_OPCODE = 24'h0F01D5;
endpackage

// File: rtl/txn_depth_ctr.sv
module txn_depth_ctr #(
    parameter int MAX_DEPTH = 7,
    localparam int DW = $clog2(MAX_DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          inc,
    input  logic          dec,
    input  logic          clr,
    output logic [DW-1:0] cnt,
    output logic          at_zero,
    output logic          at_one,
    output logic          at_max
);
    always_ff @(posedge clk) begin
        if (!rst_n)   cnt <= '0;
        else if (clr) cnt <= '0;
        else if (inc) cnt <= cnt + 1'b1;
        else if (dec) cnt <= cnt - 1'b1;
    end

    assign at_zero = (cnt == '0);
    assign at_one  = (cnt == DW'(1));
    assign at_max  = (cnt == DW'(MAX_DEPTH));
endmodule

// File: rtl/txn_fallback.sv
module txn_fallback #(
    parameter int PC_W = 64,
    localparam int NARROW_W = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cap,
    input  logic [PC_W-1:0] fb_in,
    input  logic            mode64,
    output logic [PC_W-1:0] pc_out
);
    logic [PC_W-1:0] fb_q;

    always_ff @(posedge clk) begin
        if (!rst_n)   fb_q <= '0;
        else if (cap) fb_q <= fb_in;
    end

    generate
        if (PC_W > NARROW_W) begin : g_wide
            assign pc_out = mode64 ? fb_q : {{(PC_W-NARROW_W){1'b0}}, fb_q[NARROW_W-1:0]};
        end else begin : g_narrow
            logic unused_mode;
            assign unused_mode = mode64;
            assign pc_out = fb_q;
        end
    endgenerate
endmodule

// File: rtl/txn_nest_ctrl.sv
module txn_nest_ctrl
    import txn_pkg::*;
#(
    parameter int MAX_DEPTH = 7,
    parameter int PC_W = 64,
    localparam int DW = $clog2(MAX_DEPTH + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                feat_en,
    input  logic                mode64,
    input  logic                lock_pfx,
    input  logic                other_pfx,
    input  logic                begin_v,
    input  logic [PC_W-1:0]     begin_fb,
    input  logic                end_v,
    input  logic [OPC_W-1:0]    end_opc,
    input  logic                susp_set,
    input  logic                susp_clr,
    input  logic                ext_abort,
    input  logic                commit_rsp_v,
    input  logic                commit_rsp_ok,
    output logic                stall_o,
    output logic                commit_req,
    output logic                fault_ud,
    output logic                fault_gp,
    output logic                restore_o,
    output logic                discard_o,
    output logic [CAUSE_W-1:0]  status_o,
    output logic                redirect_v,
    output logic [PC_W-1:0]     redirect_pc,
    output logic                active_o,
    output logic [DW-1:0]       depth_o
);
    txn_state_e         state_q, state_d;
    logic               susp_q, susp_d;
    logic [CAUSE_W-1:0] cause_q, cause_d;
    logic               ud_d, gp_d, abort_d;
    logic               inc, dec, cap;
    logic               at_zero, at_one, at_max;
    logic               end_hit;

    // R2: exact opcode bytes, no other prefix
    assign end_hit = end_v && (end_opc == END_OPCODE) && !other_pfx;

    txn_depth_ctr #(.MAX_DEPTH(MAX_DEPTH)) u_depth (
        .clk(clk), .rst_n(rst_n), .inc(inc), .dec(dec), .clr(abort_d),
        .cnt(depth_o), .at_zero(at_zero), .at_one(at_one), .at_max(at_max)
    );

    txn_fallback #(.PC_W(PC_W)) u_fb (
        .clk(clk), .rst_n(rst_n), .cap(cap), .fb_in(begin_fb),
        .mode64(mode64), .pc_out(redirect_pc)   // R9
    );

    // next-state and control decode
    always_comb begin
        state_d = state_q;
        susp_d  = susp_q;
        cause_d = '0;
        ud_d    = 1'b0;
        gp_d    = 1'b0;
        abort_d = 1'b0;
        inc     = 1'b0;
        dec     = 1'b0;
        cap     = 1'b0;
        unique case (state_q)
            ST_IDLE, ST_RUN: begin
                if (ext_abort && state_q == ST_RUN) begin          // R12
                    abort_d = 1'b1;
                    cause_d[CAUSE_EXT] = 1'b1;
                end else if (begin_v) begin
                    if (!feat_en) begin                            // R3
                        ud_d = 1'b1;
                    end else if (at_max) begin                     // R11
                        abort_d = 1'b1;
                        cause_d[CAUSE_OVF] = 1'b1;
                    end else begin                                 // R5
                        inc     = 1'b1;
                        cap     = at_zero;
                        state_d = ST_RUN;
                    end
                end else if (end_hit) begin
                    if (!feat_en || lock_pfx) begin                // R3
                        ud_d = 1'b1;
                    end else if (state_q == ST_IDLE) begin         // R4
                        gp_d = 1'b1;
                    end else if (susp_q) begin                     // R10
                        abort_d = 1'b1;
                        cause_d[CAUSE_SUSP] = 1'b1;
                    end else begin                                 // R6
                        dec = 1'b1;
                        if (at_one) state_d = ST_COMMIT;
                    end
                end else if (state_q == ST_RUN) begin              // R10
                    if (susp_set)      susp_d = 1'b1;
                    else if (susp_clr) susp_d = 1'b0;
                end
            end
            ST_COMMIT: begin
                if (ext_abort) begin                               // R12
                    abort_d = 1'b1;
                    cause_d[CAUSE_EXT] = 1'b1;
                end else if (commit_rsp_v) begin                   // R7
                    if (commit_rsp_ok) begin
                        state_d = ST_IDLE;
                    end else begin
                        abort_d = 1'b1;
                        cause_d[CAUSE_CONFLICT] = 1'b1;
                    end
                end
            end
            ST_ABORT: state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
        if (abort_d) begin                                         // R8
            state_d = ST_ABORT;
            susp_d  = 1'b0;
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // registered outputs and flags
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            susp_q   <= 1'b0;
            cause_q  <= '0;
            fault_ud <= 1'b0;
            fault_gp <= 1'b0;
        end else begin
            susp_q   <= susp_d;
            fault_ud <= ud_d;
            fault_gp <= gp_d;
            if (abort_d) cause_q <= cause_d;
        end
    end

    assign active_o   = (state_q == ST_RUN) || (state_q == ST_COMMIT);
    assign commit_req = (state_q == ST_COMMIT);
    assign restore_o  = (state_q == ST_ABORT);
    assign discard_o  = (state_q == ST_ABORT);
    assign redirect_v = (state_q == ST_ABORT);
    assign status_o   = (state_q == ST_ABORT) ? cause_q : '0;
    assign stall_o    = (state_q == ST_COMMIT) || (state_q == ST_ABORT);
endmodule

// File: rtl/txn_nest_chk.sv
module txn_nest_chk #(
    parameter int MAX_DEPTH = 7,
    localparam int DW = $clog2(MAX_DEPTH + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          ext_abort,
    input logic          commit_rsp_v,
    input logic          commit_req,
    input logic          fault_ud,
    input logic          fault_gp,
    input logic          restore_o,
    input logic          discard_o,
    input logic          active_o,
    input logic [DW-1:0] depth_o
);
    AST_COMMIT_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(commit_req) |-> (depth_o == '0) && active_o);                       // R6
    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        commit_req && !commit_rsp_v && !ext_abort |=> commit_req);                // R6
    AST_GP_NO_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
        fault_gp |-> !active_o && depth_o == '0);                                  // R4
    AST_UD_NO_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
        fault_ud && !restore_o |-> depth_o == $past(depth_o));                      // R3
    AST_ABORT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        restore_o |-> !active_o && depth_o == '0 && discard_o);                     // R8
    AST_ABORT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        restore_o |=> !restore_o);                                                 // R8
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        depth_o <= DW'(MAX_DEPTH));                                                // R11
endmodule

bind txn_nest_ctrl txn_nest_chk #(.MAX_DEPTH(MAX_DEPTH)) u_chk (
    .clk(clk), .rst_n(rst_n), .ext_abort(ext_abort), .commit_rsp_v(commit_rsp_v),
    .commit_req(commit_req), .fault_ud(fault_ud), .fault_gp(fault_gp),
    .restore_o(restore_o), .discard_o(discard_o), .active_o(active_o), .depth_o(depth_o)
);

// File: tb/txn_nest_ctrl_test.sv
`timescale 1ns/1ps
module txn_nest_ctrl_test;
    localparam int MAXD = 7;
    localparam int DW   = $clog2(MAXD + 1);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic feat_en, mode64, lock_pfx, other_pfx, begin_v, end_v;
    logic susp_set, susp_clr, ext_abort, commit_rsp_v, commit_rsp_ok;
    logic [63:0] begin_fb;
    logic [23:0] end_opc;
    logic stall_o, commit_req, fault_ud, fault_gp, restore_o, discard_o, redirect_v, active_o;
    logic [3:0]  status_o;
    logic [63:0] redirect_pc;
    logic [DW-1:0] depth_o;

    always #4 clk = ~clk;   // 125 MHz

    txn_nest_ctrl #(.MAX_DEPTH(MAXD)) uut (.*);

    typedef struct {
        string tag;
        logic ud, gp, creq, abrt, act;
        logic [3:0] st;
        logic [63:0] pc;
        int depth;
    } exp_t;

    exp_t q[$];
    int vectors = 0;
    int miscompares = 0;

    // reference model state
    int  m_depth = 0;
    logic m_act = 0, m_susp = 0;
    logic [63:0] m_fb = '0;
    int  m_st = 0;          // 0 normal, 1 commit pending, 2 abort cycle
    logic [3:0] m_cause = '0;

    task automatic m_abort(input logic [3:0] c);
        m_depth = 0; m_act = 0; m_susp = 0; m_st = 2; m_cause = c;
    endtask

    task automatic idle_inputs();
        lock_pfx = 0; other_pfx = 0; begin_v = 0; end_v = 0; end_opc = 24'h0F01D5;
        susp_set = 0; susp_clr = 0; ext_abort = 0; commit_rsp_v = 0; commit_rsp_ok = 0;
    endtask

    // driver: predicts the post-edge outputs, pushes them, then clocks
    task automatic step(input string tag);
        exp_t e;
        logic end_hit;
        e.tag = tag; e.ud = 0; e.gp = 0;
        end_hit = end_v && end_opc == 24'h0F01D5 && !other_pfx;
        if (m_st == 2) m_st = 0;
        else if (ext_abort && m_act) m_abort(4'b0001);
        else if (m_st == 1) begin
            if (commit_rsp_v) begin
                if (commit_rsp_ok) begin m_act = 0; m_st = 0; end
                else m_abort(4'b0010);
            end
        end else if (begin_v) begin
            if (!feat_en) e.ud = 1;
            else if (m_depth == MAXD) m_abort(4'b0100);
            else begin if (m_depth == 0) m_fb = begin_fb; m_depth++; m_act = 1; end
        end else if (end_hit) begin
            if (!feat_en || lock_pfx) e.ud = 1;
            else if (!m_act) e.gp = 1;
            else if (m_susp) m_abort(4'b1000);
            else begin m_depth--; if (m_depth == 0) m_st = 1; end
        end else if (m_act) begin
            if (susp_set) m_susp = 1; else if (susp_clr) m_susp = 0;
        end
        e.creq  = (m_st == 1);
        e.abrt  = (m_st == 2);
        e.st    = e.abrt ? m_cause : 4'b0;
        e.pc    = mode64 ? m_fb : {32'b0, m_fb[31:0]};
        e.act   = m_act;
        e.depth = m_depth;
        q.push_back(e);
        @(posedge clk);
        @(negedge clk);
        idle_inputs();
    endtask

    // monitor: compares after each edge
    always @(posedge clk) begin
        #1;
        if (q.size() > 0) begin
            exp_t e;
            logic bad;
            e = q.pop_front();
            bad = 0;
            vectors++;
            if (fault_ud !== e.ud || fault_gp !== e.gp) begin
                bad = 1;
                $display("FAIL %s faults ud/gp got %b%b exp %b%b", e.tag, fault_ud, fault_gp, e.ud, e.gp);
            end
            if (commit_req !== e.creq || stall_o !== (e.creq | e.abrt)) begin
                bad = 1;
                $display("FAIL %s commit_req/stall got %b%b exp %b%b", e.tag, commit_req, stall_o, e.creq, e.creq | e.abrt);
            end
            if (restore_o !== e.abrt || discard_o !== e.abrt || redirect_v !== e.abrt || status_o !== e.st) begin
                bad = 1;
                $display("FAIL %s abort r/d/v/st got %b%b%b %h exp %b %h", e.tag, restore_o, discard_o, redirect_v, status_o, e.abrt, e.st);
            end
            if (e.abrt && redirect_pc !== e.pc) begin
                bad = 1;
                $display("FAIL %s redirect_pc got %h exp %h", e.tag, redirect_pc, e.pc);
            end
            if (active_o !== e.act || int'(depth_o) != e.depth) begin
                bad = 1;
                $display("FAIL %s active/depth got %b/%0d exp %b/%0d", e.tag, active_o, depth_o, e.act, e.depth);
            end
            if (bad) miscompares++;
        end
    end

    initial begin
        #(8 * 20000);
        miscompares++;
        $display("FAIL watchdog expired got hung exp done");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        feat_en = 1; mode64 = 1; begin_fb = '0;
        idle_inputs();
        repeat (3) @(negedge clk);
        rst_n = 1;
        step("R1 reset state");

        end_v = 1; step("R4 end while inactive");
        feat_en = 0; end_v = 1; step("R3 end with feature off");
        begin_v = 1; begin_fb = 64'h11; step("R3 begin with feature off");
        feat_en = 1;

        begin_v = 1; begin_fb = 64'hAAAA_0000_0000_1000; step("R5 outer begin");
        begin_v = 1; begin_fb = 64'hBBBB_0000_0000_2000; step("R5 inner begin");
        end_v = 1; lock_pfx = 1; step("R3 end with lock");
        end_v = 1; end_opc = 24'h0F01D6; step("R2 wrong opcode ignored");
        end_v = 1; other_pfx = 1; step("R2 prefixed end ignored");
        end_v = 1; step("R6 inner end");
        end_v = 1; step("R6 outer end commit");
        begin_v = 1; begin_fb = 64'h55; step("R6 begin stalled");
        step("R6 request held");
        commit_rsp_v = 1; commit_rsp_ok = 1; step("R7 commit pass");
        ext_abort = 1; step("R12 abort ignored while idle");

        mode64 = 0;
        begin_v = 1; begin_fb = 64'hDEAD_BEEF_CAFE_0040; step("R5 begin 32-bit mode");
        end_v = 1; step("R6 end to commit");
        commit_rsp_v = 1; commit_rsp_ok = 0; step("R7 commit fail abort R9");
        step("R8 back to idle");
        mode64 = 1;

        begin_v = 1; begin_fb = 64'h0123_4567_89AB_CDE0; step("R5 begin");
        susp_set = 1; step("R10 suspend");
        end_v = 1; step("R10 end while suspended");
        step("R8 idle after abort");

        begin_v = 1; begin_fb = 64'h700; step("R10 begin");
        susp_set = 1; step("R10 suspend");
        susp_clr = 1; step("R10 resume");
        end_v = 1; step("R10 end after resume commits");
        ext_abort = 1; commit_rsp_v = 1; commit_rsp_ok = 1; step("R12 abort beats response");
        step("R8 idle");

        for (int i = 0; i < MAXD; i++) begin
            begin_v = 1; begin_fb = 64'h9000 + 64'(i); step("R11 fill depth");
        end
        begin_v = 1; begin_fb = 64'hFFFF; step("R11 overflow abort");
        step("R8 idle after overflow");

        begin_v = 1; begin_fb = 64'h4242; step("R5 begin");
        ext_abort = 1; end_v = 1; step("R12 abort beats end");
        step("R1 settle");

        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule